// File: doc/BRIEF.md
# Dual-Line Serial Target Bridge to a Word Memory Port

This block sits inside an FPGA and lets an external host controller reach a 32-bit byte-addressed internal memory space over a half-duplex serial link. The link uses clock polarity and phase mode 0, with two data lines that each carry one bit per serial clock. Every transaction opens with an 8-bit command and a 32-bit byte address. Memory writes then stream data bytes from the host. Memory reads insert a gap of idle clocks first. The gap length depends on the low address bits, so a word-wide memory can serve reads that start on any byte.

The command byte also carries the interrupt traffic. A two-bit field lets the host raise one of three events toward the FPGA. A second two-bit field lets the host clear one of three pending FPGA-to-host events. Internal logic posts events into a small pending set. An active-low interrupt output stays low for as long as any event is still pending. A read at address zero that carries no codes returns a 32-bit status word instead of memory data. The host uses it to see which events are pending.

The serial pins are synchronised into the system clock and oversampled. Memory accesses leave through a request/ready port, one 32-bit word with byte enables at a time.

Top module: `dspi_bridge`

## Requirements
- R1: Mode-0 framing. With chip select low, both data lines are sampled on each rising serial clock. In each two-bit pair, line 1 carries the more significant bit. The first 4 clocks carry the command byte MSB first. The next 16 clocks carry the 32-bit address MSB first.
- R2: Write data (command bit 4 = 0). Each received byte is placed in the lane of the 32-bit word given by its address bits 1:0, with lane k at bits 8k+7:8k. The byte address then increments. When lane 3 is filled, one write request goes out. It carries word address = byte address bits 31:2, and enables bit k set for each lane filled since the last flush.
- R3: Raising chip select at any point ends the transaction and returns the engine to the command phase. A partly assembled write word is dropped without any memory request.
- R4: Memory read (command bit 4 = 1). After the address come 8 + 2×(address bits 1:0) idle clocks. Data bytes then follow from the addressed byte onward, in increasing address order and continuing into the following words. Each byte is sent MSB first. Data is driven after the falling serial clock.
- R5: A read whose command bits 3:0 are all zero and whose address is 0 has no idle gap. It returns the 32-bit status word MSB first. Bits 31:24 hold the STATUS_TAG parameter, bits 23:3 are zero, and bit k-1 shows whether event code k (1..3) is pending.
- R6: A nonzero code k in command bits 1:0 produces a one-cycle pulse on host_irq bit k-1. This happens even when a write carries no data bytes. No memory access results from a write with no data.
- R7: A pulse on irq_set bit k-1 marks event code k as pending. irq_n is low on the cycle after, and stays low while any event is pending.
- R8: A nonzero code k in command bits 3:2 clears pending code k. irq_n returns high only when no code remains pending. Without such a clear, irq_n stays low. A set in the same cycle as a clear of the same code keeps it pending.
- R9: Once mem_req is raised, mem_req, mem_we and mem_addr hold steady until mem_ready is seen.
- R10: spi_io_oe is high only during the data phase of a read. It falls once chip select rises, and it is never high during a write.
- R11: After reset, irq_n is high, spi_io_oe, mem_req and host_irq are low, and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from host |
| spi_cs_n | input | 1 | Active-low chip select from host |
| spi_io_in | input | 2 | Data lines as seen from the pads |
| spi_io_out | output | 2 | Data driven toward the host |
| spi_io_oe | output | 1 | Output enable for both data lines |
| irq_n | output | 1 | Active-low interrupt to host |
| irq_set | input | 3 | Pulses posting event codes 3..1 |
| host_irq | output | 3 | One-cycle pulses for host-raised codes 3..1 |
| mem_req | output | 1 | Memory request, held until ready |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W-2 | Word address |
| mem_wdata | output | 32 | Write word |
| mem_be | output | 4 | Byte enables of the write |
| mem_ready | input | 1 | Memory accepts or completes the request |
| mem_rdata | input | 32 | Read word, valid with mem_ready |

## Verification
The bench goes after the read offsets 1 and 3. A design with the wrong gap length, or one that starts at byte 0, returns shifted bytes. The bench also checks the crossing into the next word, which a design without a working prefetch fills with stale data. Writes that begin mid-word must show only the upper enables and must leave the lower bytes of memory untouched. A write cut short by chip select must issue nothing; a design that flushes partial words corrupts memory. For interrupts, the bench clears one of two pending codes and checks that the line stays low, then clears the second and checks that it rises. It also sends a write with no data that carries only a raise code, which must pulse the right host bit and touch no memory.

// File: rtl/dspi_pkg.sv
package dspi_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_ADDR,
    PH_DUMMY,
    PH_RDATA,
    PH_WDATA
  } phase_t;

  // Reorder a little-endian word so byte 'off' leaves first, each byte MSB first.
  function automatic logic [WORD_W-1:0] ser_word(input logic [WORD_W-1:0] w,
                                                 input logic [1:0] off);
    logic [WORD_W-1:0] r;
    logic [1:0] k;
    r = '0;
    for (int i = 0; i < 4; i++) begin
      k = off + 2'(i);
      r[31-8*i -: 8] = w[{k, 3'b000} +: 8];
    end
    return r;
  endfunction

endpackage

// File: rtl/dspi_sync.sv
module dspi_sync #(
  parameter int            W       = 1,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/dspi_irq.sv
module dspi_irq #(
  parameter int NCODE = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCODE-1:0] raise,
  input  logic             ack_stb,
  input  logic [1:0]       ack_code,
  output logic [NCODE-1:0] pend,
  output logic             irq_n
);

  logic [NCODE-1:0] clr, nxt;

  always_comb begin
    clr = '0;
    if (ack_stb && ack_code != 2'd0)
      clr = NCODE'(1) << (ack_code - 2'd1);
    nxt = (pend & ~clr) | raise;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend  <= '0;
      irq_n <= 1'b1;
    end else begin
      pend  <= nxt;
      irq_n <= ~|nxt;
    end
  end

endmodule

// File: rtl/dspi_mem.sv
module dspi_mem #(
  parameter int ADDR_W = 32,
  localparam int WA_W  = ADDR_W - 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fetch_stb,
  input  logic [WA_W-1:0] fetch_addr,
  input  logic            flush_stb,
  input  logic [WA_W-1:0] flush_addr,
  input  logic [31:0]     flush_data,
  input  logic [3:0]      flush_be,
  output logic            mem_req,
  output logic            mem_we,
  output logic [WA_W-1:0] mem_addr,
  output logic [31:0]     mem_wdata,
  output logic [3:0]      mem_be,
  input  logic            mem_ready,
  input  logic [31:0]     mem_rdata,
  output logic [31:0]     rbuf
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_be    <= '0;
      rbuf      <= '0;
    end else begin
      if (mem_req && mem_ready) begin
        mem_req <= 1'b0;
        if (!mem_we) rbuf <= mem_rdata;
      end
      if (fetch_stb) begin
        mem_req  <= 1'b1;
        mem_we   <= 1'b0;
        mem_addr <= fetch_addr;
        mem_be   <= 4'hF;
      end else if (flush_stb) begin
        mem_req   <= 1'b1;
        mem_we    <= 1'b1;
        mem_addr  <= flush_addr;
        mem_wdata <= flush_data;
        mem_be    <= flush_be;
      end
    end
  end

endmodule

// File: rtl/dspi_bridge.sv
module dspi_bridge
  import dspi_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  STATUS_TAG  = 8'hC3,
  localparam int         WA_W        = ADDR_W - 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            spi_sclk,
  input  logic            spi_cs_n,
  input  logic [1:0]      spi_io_in,
  output logic [1:0]      spi_io_out,
  output logic            spi_io_oe,
  output logic            irq_n,
  input  logic [2:0]      irq_set,
  output logic [2:0]      host_irq,
  output logic            mem_req,
  output logic            mem_we,
  output logic [WA_W-1:0] mem_addr,
  output logic [31:0]     mem_wdata,
  output logic [3:0]      mem_be,
  input  logic            mem_ready,
  input  logic [31:0]     mem_rdata
);

  // pin synchronisation and edge detection
  logic [3:0] pins_s;
  logic       cs_s, sclk_s, sclk_q, rise, fall;
  logic [1:0] io_s;

  dspi_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) u_sync (
    .clk(clk), .rst(rst),
    .d({spi_cs_n, spi_sclk, spi_io_in}),
    .q(pins_s)
  );

  assign cs_s   = pins_s[3];
  assign sclk_s = pins_s[2];
  assign io_s   = pins_s[1:0];

  always_ff @(posedge clk) begin
    if (rst) sclk_q <= 1'b0;
    else     sclk_q <= sclk_s;
  end

  assign rise = sclk_s & ~sclk_q & ~cs_s;
  assign fall = ~sclk_s & sclk_q & ~cs_s;

  // frame engine state
  phase_t            phase;
  logic [3:0]        cnt;
  logic [29:0]       sh;
  logic [4:0]        cmd_q;
  logic [3:0]        dcnt;
  logic [1:0]        off;
  logic [31:0]       out_sh;
  logic [4:0]        rem;
  logic              st_mode;
  logic [ADDR_W-1:0] wptr;
  logic [31:0]       wword, wword_n;
  logic [3:0]        wbe;
  logic              ack_stb;
  logic [1:0]        ack_code;
  logic              fetch_stb, flush_stb;
  logic [WA_W-1:0]   fetch_addr, flush_addr;
  logic [31:0]       flush_data;
  logic [3:0]        flush_be;
  logic [31:0]       rbuf;
  logic [2:0]        pend;

  logic [7:0]        cmd_w;
  logic [31:0]       addr_w;
  logic [7:0]        byte_w;
  logic [31:0]       status_w;
  logic [31:0]       src;

  assign cmd_w    = {sh[5:0], io_s};
  assign addr_w   = {sh, io_s};
  assign byte_w   = {sh[5:0], io_s};
  assign status_w = {STATUS_TAG, 21'd0, pend};

  always_comb begin
    wword_n = wword;
    wword_n[{wptr[1:0], 3'b000} +: 8] = byte_w;
  end

  always_comb begin
    if (rem == 5'd0) src = st_mode ? 32'd0 : ser_word(rbuf, 2'd0);
    else             src = out_sh;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_CMD;
      cnt        <= '0;
      sh         <= '0;
      cmd_q      <= '0;
      dcnt       <= '0;
      off        <= '0;
      out_sh     <= '0;
      rem        <= '0;
      st_mode    <= 1'b0;
      wptr       <= '0;
      wword      <= '0;
      wbe        <= '0;
      ack_stb    <= 1'b0;
      ack_code   <= '0;
      host_irq   <= '0;
      fetch_stb  <= 1'b0;
      fetch_addr <= '0;
      flush_stb  <= 1'b0;
      flush_addr <= '0;
      flush_data <= '0;
      flush_be   <= '0;
      spi_io_out <= '0;
      spi_io_oe  <= 1'b0;
    end else begin
      host_irq  <= '0;
      ack_stb   <= 1'b0;
      fetch_stb <= 1'b0;
      flush_stb <= 1'b0;
      if (cs_s) begin
        phase     <= PH_CMD;
        cnt       <= '0;
        wbe       <= '0;
        st_mode   <= 1'b0;
        spi_io_oe <= 1'b0;
      end else if (rise) begin
        sh  <= {sh[27:0], io_s};
        cnt <= cnt + 4'd1;
        case (phase)
          PH_CMD: if (cnt == 4'd3) begin
            cmd_q    <= cmd_w[4:0];
            cnt      <= '0;
            phase    <= PH_ADDR;
            if (cmd_w[1:0] != 2'd0) host_irq <= 3'b001 << (cmd_w[1:0] - 2'd1);
            ack_stb  <= (cmd_w[3:2] != 2'd0);
            ack_code <= cmd_w[3:2];
          end
          PH_ADDR: if (cnt == 4'd15) begin
            cnt <= '0;
            if (!cmd_q[4]) begin
              phase <= PH_WDATA;
              wptr  <= addr_w[ADDR_W-1:0];
              wbe   <= '0;
            end else if (cmd_q[3:0] == 4'd0 && addr_w == 32'd0) begin
              phase   <= PH_RDATA;
              st_mode <= 1'b1;
              out_sh  <= status_w;
              rem     <= 5'd16;
            end else begin
              phase      <= PH_DUMMY;
              dcnt       <= 4'd8 + {1'b0, addr_w[1:0], 1'b0};
              off        <= addr_w[1:0];
              fetch_stb  <= 1'b1;
              fetch_addr <= addr_w[ADDR_W-1:2];
            end
          end
          PH_DUMMY: begin
            if (dcnt == 4'd1) begin
              phase      <= PH_RDATA;
              out_sh     <= ser_word(rbuf, off);
              rem        <= 5'd16 - {1'b0, off, 2'b00};
              fetch_stb  <= 1'b1;
              fetch_addr <= fetch_addr + 1'b1;
            end else begin
              dcnt <= dcnt - 4'd1;
            end
          end
          PH_WDATA: if (cnt[1:0] == 2'd3) begin
            wword <= wword_n;
            wptr  <= wptr + 1'b1;
            if (wptr[1:0] == 2'd3) begin
              flush_stb  <= 1'b1;
              flush_addr <= wptr[ADDR_W-1:2];
              flush_data <= wword_n;
              flush_be   <= wbe | 4'b1000;
              wbe        <= '0;
            end else begin
              wbe[wptr[1:0]] <= 1'b1;
            end
          end
          default: ;
        endcase
      end else if (fall && phase == PH_RDATA) begin
        spi_io_oe  <= 1'b1;
        spi_io_out <= src[31:30];
        out_sh     <= {src[29:0], 2'b00};
        if (rem == 5'd0) begin
          rem <= 5'd15;
          if (!st_mode) begin
            fetch_stb  <= 1'b1;
            fetch_addr <= fetch_addr + 1'b1;
          end
        end else begin
          rem <= rem - 5'd1;
        end
      end
    end
  end

  dspi_irq #(.NCODE(3)) u_irq (
    .clk(clk), .rst(rst),
    .raise(irq_set),
    .ack_stb(ack_stb), .ack_code(ack_code),
    .pend(pend), .irq_n(irq_n)
  );

  dspi_mem #(.ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .rst(rst),
    .fetch_stb(fetch_stb), .fetch_addr(fetch_addr),
    .flush_stb(flush_stb), .flush_addr(flush_addr),
    .flush_data(flush_data), .flush_be(flush_be),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .rbuf(rbuf)
  );

endmodule

// File: rtl/dspi_bridge_chk.sv
module dspi_bridge_chk #(
  parameter int ADDR_W = 32,
  localparam int WA_W  = ADDR_W - 2
) (
  input logic            clk,
  input logic            rst,
  input logic            cs_s,
  input logic            irq_n,
  input logic [2:0]      irq_set,
  input logic            ack_stb,
  input logic [2:0]      host_irq,
  input logic            mem_req,
  input logic            mem_ready,
  input logic            mem_we,
  input logic [WA_W-1:0] mem_addr,
  input logic [3:0]      mem_be,
  input logic            spi_io_oe
);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R9

  AST_WRITE_WORD_END: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we |-> mem_be[3]); // R2

  AST_OE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> !spi_io_oe); // R10

  AST_SET_PULLS_LOW: assert property (@(posedge clk) disable iff (rst)
    (irq_set != 3'd0) |=> !irq_n); // R7

  AST_LOW_UNTIL_ACK: assert property (@(posedge clk) disable iff (rst)
    !irq_n && !ack_stb |=> !irq_n); // R8

  AST_HOST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(host_irq)); // R6

endmodule

bind dspi_bridge dspi_bridge_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .cs_s(cs_s), .irq_n(irq_n), .irq_set(irq_set),
  .ack_stb(ack_stb), .host_irq(host_irq), .mem_req(mem_req),
  .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_be(mem_be), .spi_io_oe(spi_io_oe)
);

// File: tb/dspi_bridge_test.sv
module dspi_bridge_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        spi_sclk = 1'b0;
  logic        spi_cs_n = 1'b1;
  logic [1:0]  spi_io_in = 2'b00;
  logic [1:0]  spi_io_out;
  logic        spi_io_oe;
  logic        irq_n;
  logic [2:0]  irq_set = 3'b000;
  logic [2:0]  host_irq;
  logic        mem_req, mem_we;
  logic [29:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [3:0]  mem_be;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_rdata = 32'd0;

  dspi_bridge uut (
    .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_io_in(spi_io_in), .spi_io_out(spi_io_out), .spi_io_oe(spi_io_oe),
    .irq_n(irq_n), .irq_set(irq_set), .host_irq(host_irq),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  always #10 clk = ~clk;

  int total = 0, fails = 0;
  bit done = 0;
  logic [31:0] mem [16];
  logic [7:0]  wbuf [16];
  logic [7:0]  rbyte [16];
  int          wr_count = 0, hs_bad = 0, oe_bad = 0, wait_cnt = 0;
  logic [3:0]  last_be = '0;
  logic [29:0] held_addr = '0;
  logic [2:0]  hirq_seen = '0;
  bit          wr_frame = 0;

  // memory model: ready two cycles after a request appears
  always @(negedge clk) begin
    if (mem_ready) mem_ready = 1'b0;
    else if (mem_req) begin
      if (wait_cnt > 0 && mem_addr != held_addr) hs_bad++;
      held_addr = mem_addr;
      if (wait_cnt == 2) begin
        mem_ready = 1'b1;
        wait_cnt = 0;
        if (mem_we) begin
          for (int k = 0; k < 4; k++)
            if (mem_be[k]) mem[mem_addr[3:0]][8*k +: 8] = mem_wdata[8*k +: 8];
          wr_count++;
          last_be = mem_be;
        end else mem_rdata = mem[mem_addr[3:0]];
      end else wait_cnt++;
    end else wait_cnt = 0;
  end

  always @(negedge clk) begin
    hirq_seen = hirq_seen | host_irq;
    if (spi_io_oe && wr_frame) oe_bad++;
  end

  function automatic logic [7:0] mbyte(input logic [5:0] a);
    return mem[a[5:2]][{a[1:0], 3'b000} +: 8];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_pair(input logic [1:0] p);
    spi_io_in = p;
    wclk(6); spi_sclk = 1'b1;
    wclk(6); spi_sclk = 1'b0;
  endtask

  task automatic recv_pair(output logic [1:0] p);
    spi_io_in = 2'b00;
    wclk(6); p = spi_io_out; spi_sclk = 1'b1;
    wclk(6); spi_sclk = 1'b0;
  endtask

  task automatic frame(input logic [7:0] cmd, input logic [31:0] addr,
                       input int ndummy, input int nw, input int nr);
    logic [1:0] p;
    wr_frame = !cmd[4];
    spi_cs_n = 1'b0; wclk(4);
    for (int i = 3; i >= 0; i--) send_pair(cmd[2*i+1 -: 2]);
    for (int i = 15; i >= 0; i--) send_pair(addr[2*i+1 -: 2]);
    for (int i = 0; i < ndummy; i++) send_pair(2'b00);
    for (int b = 0; b < nw; b++)
      for (int i = 3; i >= 0; i--) send_pair(wbuf[b][2*i+1 -: 2]);
    for (int b = 0; b < nr; b++) begin
      for (int i = 0; i < 4; i++) begin
        recv_pair(p);
        rbyte[b] = {rbyte[b][5:0], p};
      end
    end
    wclk(6); spi_cs_n = 1'b1; wclk(12);
    wr_frame = 0;
  endtask

  task automatic read_status(output logic [31:0] s);
    frame(8'h10, 32'h0, 0, 0, 4);
    s = {rbyte[0], rbyte[1], rbyte[2], rbyte[3]};
  endtask

  task automatic t_reset;
    check("R11 irq_n", 32'(irq_n), 32'd1);
    check("R11 oe", 32'(spi_io_oe), 32'd0);
    check("R11 mem_req", 32'(mem_req), 32'd0);
    check("R11 host_irq", 32'(host_irq), 32'd0);
  endtask

  task automatic t_hello;
    int w0 = wr_count;
    hirq_seen = '0;
    frame(8'h02, 32'h0, 0, 0, 0);
    check("R6 hello pulse", 32'(hirq_seen), 32'h2);
    check("R6 no memory write", 32'(wr_count), 32'(w0));
  endtask

  task automatic t_write_aligned;
    int w0 = wr_count;
    for (int b = 0; b < 8; b++) wbuf[b] = 8'h10 + 8'(b);
    frame(8'h00, 32'h4000_0010, 0, 8, 0);
    check("R2 two words written", 32'(wr_count), 32'(w0 + 2));
    check("R2 word4", mem[4], 32'h1312_1110);
    check("R2 word5", mem[5], 32'h1716_1514);
    check("R2 full enables", 32'(last_be), 32'hF);
  endtask

  task automatic t_write_offset;
    mem[7] = 32'h5555_5555;
    wbuf[0] = 8'hAA; wbuf[1] = 8'hBB;
    frame(8'h00, 32'h4000_001E, 0, 2, 0);
    check("R2 upper lanes only", mem[7], 32'hBBAA_5555);
    check("R2 enables 1100", 32'(last_be), 32'hC);
  endtask

  task automatic t_abort;
    int w0 = wr_count;
    mem[6] = 32'h1122_3344;
    wbuf[0] = 8'hDE; wbuf[1] = 8'hAD; wbuf[2] = 8'hBE;
    frame(8'h00, 32'h4000_0018, 0, 3, 0);
    check("R3 partial word dropped", 32'(wr_count), 32'(w0));
    check("R3 memory untouched", mem[6], 32'h1122_3344);
    frame(8'h10, 32'h4000_0018, 8, 0, 4);
    check("R3 R1 framing restarts", {rbyte[3], rbyte[2], rbyte[1], rbyte[0]}, 32'h1122_3344);
  endtask

  task automatic t_read(input logic [5:0] a, input int n);
    frame(8'h10, {26'h100_0000, a}, 8 + 2 * int'(a[1:0]), 0, n);
    for (int b = 0; b < n; b++)
      check($sformatf("R4 R1 read byte %0d off %0d", b, a[1:0]),
            32'(rbyte[b]), 32'(mbyte(a + 6'(b))));
    check("R10 oe released", 32'(spi_io_oe), 32'd0);
  endtask

  task automatic t_irq;
    logic [31:0] s;
    @(negedge clk); irq_set = 3'b101; @(negedge clk); irq_set = 3'b000;
    wclk(2);
    check("R7 irq_n low", 32'(irq_n), 32'd0);
    read_status(s);
    check("R5 status pending 1,3", s, 32'hC300_0005);
    frame(8'h04, 32'h0, 0, 0, 0);
    check("R8 still low after one clear", 32'(irq_n), 32'd0);
    read_status(s);
    check("R5 status pending 3", s, 32'hC300_0004);
    frame(8'h0C, 32'h0, 0, 0, 0);
    check("R8 high after last clear", 32'(irq_n), 32'd1);
    read_status(s);
    check("R5 status none", s, 32'hC300_0000);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'hA0B0_C0D0 ^ (32'(i) * 32'h0101_0101);
    wclk(5); rst = 1'b0; wclk(3);
    t_reset();
    t_hello();
    t_write_aligned();
    t_write_offset();
    t_abort();
    t_read(6'h10, 8);
    t_read(6'h11, 6);
    t_read(6'h17, 3);
    t_irq();
    check("R9 request held", 32'(hs_bad), 32'd0);
    check("R10 no drive during writes", 32'(oe_bad), 32'd0);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule